// File: doc/BRIEF.md
# Per-Bank First-Ready Request Scheduler

This block keeps the pending memory requests of a controller in one age-ordered queue per bank. Each request carries a bank index, a row address and a transaction tag. For every bank, the bank controller presents two things: whether the bank is activated, and which row is open. The scheduler answers with the tag of the request that bank should serve next. Picking a request does not take it out of the queue. The entry leaves only when the controller reports, through a separate remove port, that the request's read or write column command has been issued.

A policy input chooses between two modes. In strict in-order mode every bank serves its head entry. In first-ready mode an activated bank prefers the oldest entry that hits its open row. The block also answers lookahead questions for one bank per cycle: does a second queued request target a given row, and is more than one request waiting. The answers count the entry that is in service, because that entry is still queued. Admission is capped by a global limit on outstanding transactions and by the depth of each bank's queue.

Top module: `frfcfs_sched`

## Requirements
- R1: A stored request is appended behind all earlier requests of the same bank. Each bank keeps its own queue, and with policy 0 (in order) the selected tag is always the oldest entry of the bank.
- R2: Selecting a request never removes it. Without a remove, the selected tag of a bank stays the same from cycle to cycle.
- R3: With policy 1 (first-ready) and the bank activated, the selection is the oldest entry whose row equals the bank's open row. If no entry matches, the selection is the oldest entry.
- R4: With policy 0, or with a precharged bank, the selection is the oldest entry. `sel_valid` is 0 and `sel_tag` is 0 for an empty bank.
- R5: With policy 1, a remove deletes the oldest entry of the named bank whose tag matches, at any position, and leaves the order of the other entries unchanged. When no entry matches, `rm_miss` is 1 in that cycle and nothing changes.
- R6: With policy 0, a remove ignores the tag and pops the head of the named bank. `rm_miss` is 1 only when that bank is empty.
- R7: With policy 1, `q_row_hit` is 1 only when at least two entries of `q_bank` have row `q_row`.
- R8: With policy 0, `q_row_hit` is 1 only when `q_bank` holds two or more entries and its second-oldest entry has row `q_row`.
- R9: `q_pending` is 1 exactly when `q_bank` holds two or more entries.
- R10: A store is rejected when the number of queued requests across all banks equals MAX_OUTSTANDING. A remove in the same cycle does not free the slot until the next cycle.
- R11: `bank_full[b]` is 1 when bank b holds DEPTH entries. A store to a full bank gives `st_accept`=0 and `st_reject`=1 and leaves the queue unchanged.
- R12: A store and a successful remove on the same bank in the same cycle both take effect. The new entry lands behind the survivors, and the entry count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy | input | 1 | 0 = strict in-order, 1 = first-ready |
| bank_active | input | NUM_BANKS | Per bank: 1 when a row is open |
| open_row | input | NUM_BANKS*ROW_W | Per bank: the open row address |
| st_en | input | 1 | Store a new request |
| st_bank | input | BANK_W | Bank of the new request |
| st_row | input | ROW_W | Row of the new request |
| st_tag | input | TAG_W | Tag of the new request |
| st_accept | output | 1 | The store is taken this cycle |
| st_reject | output | 1 | The store was refused (limit or full bank) |
| rm_en | input | 1 | Remove a served request |
| rm_bank | input | BANK_W | Bank of the served request |
| rm_tag | input | TAG_W | Tag of the served request |
| rm_miss | output | 1 | The remove found nothing to delete |
| sel_valid | output | NUM_BANKS | Per bank: a selection exists |
| sel_tag | output | NUM_BANKS*TAG_W | Per bank: the tag to serve next |
| bank_full | output | NUM_BANKS | Per bank: the queue is full |
| q_bank | input | BANK_W | Bank for the lookahead queries |
| q_row | input | ROW_W | Row for the row-hit query |
| q_row_hit | output | 1 | Answer to the row-hit query |
| q_pending | output | 1 | Answer to the pending query |

## Verification
The bench builds the block with four banks, a depth of four, 3-bit rows, 4-bit tags and MAX_OUTSTANDING of 10. The total capacity of 16 is then above the global limit, so the bench can hit the limit without any bank being full, and can fill one bank while the total is still below the limit. The narrow row field makes open-row matches, double hits and second-entry hits frequent under random stimulus. The small tags produce duplicates, which exercise the rule that removal takes the oldest match.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic {
    POL_INORDER  = 1'b0,
    POL_FIRSTRDY = 1'b1
  } policy_e;
endpackage

// File: rtl/frfcfs_bank_queue.sv
module frfcfs_bank_queue #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  frfcfs_pkg::policy_e    pol,
  input  logic                   wr_en,
  input  logic [ROW_W-1:0]       wr_row,
  input  logic [TAG_W-1:0]       wr_tag,
  input  logic                   rm_en,
  input  logic [TAG_W-1:0]       rm_tag,
  output logic                   rm_found,
  output logic                   full,
  output logic [CNT_W-1:0]       count,
  output logic [DEPTH*ROW_W-1:0] rows_flat,
  output logic [DEPTH*TAG_W-1:0] tags_flat
);
  import frfcfs_pkg::*;

  logic [ROW_W-1:0] row_q [DEPTH];
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [ROW_W-1:0] row_n [DEPTH];
  logic [TAG_W-1:0] tag_n [DEPTH];
  logic [ROW_W-1:0] row_up [DEPTH];
  logic [TAG_W-1:0] tag_up [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n, wr_slot;
  logic [IDX_W-1:0] rm_pos;
  logic             rm_do, upd;

  // neighbour above each slot, used when collapsing after a removal
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_up
    if (gi < DEPTH - 1) begin : g_mid
      assign row_up[gi] = row_q[gi+1];
      assign tag_up[gi] = tag_q[gi+1];
    end else begin : g_top
      assign row_up[gi] = '0;
      assign tag_up[gi] = '0;
    end
    assign rows_flat[gi*ROW_W +: ROW_W] = row_q[gi];
    assign tags_flat[gi*TAG_W +: TAG_W] = tag_q[gi];
  end

  // locate the entry a remove would delete
  always_comb begin
    rm_found = 1'b0;
    rm_pos   = '0;
    if (pol == POL_INORDER) begin
      rm_found = (cnt_q != '0);
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!rm_found && (CNT_W'(i) < cnt_q) && (tag_q[i] == rm_tag)) begin
          rm_found = 1'b1;
          rm_pos   = IDX_W'(i);
        end
      end
    end
  end

  assign rm_do   = rm_en && rm_found;
  assign upd     = rm_do || wr_en;
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign count   = cnt_q;
  assign wr_slot = rm_do ? (cnt_q - CNT_W'(1)) : cnt_q;

  always_comb begin
    cnt_n = cnt_q;
    if (wr_en && !rm_do) cnt_n = cnt_q + CNT_W'(1);
    if (rm_do && !wr_en) cnt_n = cnt_q - CNT_W'(1);
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      row_n[i] = row_q[i];
      tag_n[i] = tag_q[i];
      if (rm_do && (IDX_W'(i) >= rm_pos)) begin
        row_n[i] = row_up[i];
        tag_n[i] = tag_up[i];
      end
    end
    if (wr_en) begin
      row_n[IDX_W'(wr_slot)] = wr_row;
      tag_n[IDX_W'(wr_slot)] = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      for (int i = 0; i < DEPTH; i++) begin
        row_q[i] <= row_n[i];
        tag_q[i] <= tag_n[i];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full); // R11
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(rm_en && rm_found)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R1
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_en && rm_found && !wr_en) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_en && rm_found && wr_en) |=> (cnt_q == $past(cnt_q))); // R12
  AST_INORDER_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_INORDER && cnt_q != '0) |-> rm_found); // R6
endmodule

// File: rtl/frfcfs_bank_pick.sv
module frfcfs_bank_pick #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 14,
  parameter int TAG_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  frfcfs_pkg::policy_e    pol,
  input  logic                   active,
  input  logic [ROW_W-1:0]       open_row,
  input  logic [CNT_W-1:0]       count,
  input  logic [DEPTH*ROW_W-1:0] rows_flat,
  input  logic [DEPTH*TAG_W-1:0] tags_flat,
  input  logic [ROW_W-1:0]       q_row,
  output logic                   sel_valid,
  output logic [TAG_W-1:0]       sel_tag,
  output logic                   row_hit,
  output logic                   pending
);
  import frfcfs_pkg::*;

  logic [ROW_W-1:0] row_e [DEPTH];
  logic [TAG_W-1:0] tag_e [DEPTH];
  logic [IDX_W-1:0] pick;
  logic             hit_found;
  logic [CNT_W-1:0] hits;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_unpack
    assign row_e[gi] = rows_flat[gi*ROW_W +: ROW_W];
    assign tag_e[gi] = tags_flat[gi*TAG_W +: TAG_W];
  end

  // age priority: index 0 is the oldest entry
  always_comb begin
    hit_found = 1'b0;
    pick      = '0;
    if (pol == POL_FIRSTRDY && active) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (!hit_found && (CNT_W'(i) < count) && (row_e[i] == open_row)) begin
          hit_found = 1'b1;
          pick      = IDX_W'(i);
        end
      end
    end
  end

  assign sel_valid = (count != '0);
  assign sel_tag   = sel_valid ? tag_e[pick] : '0;

  always_comb begin
    hits = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) < count) && (row_e[i] == q_row)) hits = hits + CNT_W'(1);
    end
  end

  if (DEPTH > 1) begin : g_second
    assign row_hit = (pol == POL_FIRSTRDY) ? (hits >= CNT_W'(2))
                   : ((count >= CNT_W'(2)) && (row_e[1] == q_row));
  end else begin : g_single
    assign row_hit = 1'b0;
  end
  assign pending = (count >= CNT_W'(2));
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched #(
  parameter int NUM_BANKS       = 8,
  parameter int DEPTH           = 8,
  parameter int ROW_W           = 14,
  parameter int TAG_W           = 8,
  parameter int MAX_OUTSTANDING = 32,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int TOT_W  = $clog2(MAX_OUTSTANDING + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       policy,
  input  logic [NUM_BANKS-1:0]       bank_active,
  input  logic [NUM_BANKS*ROW_W-1:0] open_row,
  input  logic                       st_en,
  input  logic [BANK_W-1:0]          st_bank,
  input  logic [ROW_W-1:0]           st_row,
  input  logic [TAG_W-1:0]           st_tag,
  output logic                       st_accept,
  output logic                       st_reject,
  input  logic                       rm_en,
  input  logic [BANK_W-1:0]          rm_bank,
  input  logic [TAG_W-1:0]           rm_tag,
  output logic                       rm_miss,
  output logic [NUM_BANKS-1:0]       sel_valid,
  output logic [NUM_BANKS*TAG_W-1:0] sel_tag,
  output logic [NUM_BANKS-1:0]       bank_full,
  input  logic [BANK_W-1:0]          q_bank,
  input  logic [ROW_W-1:0]           q_row,
  output logic                       q_row_hit,
  output logic                       q_pending
);
  import frfcfs_pkg::*;

  policy_e              pol;
  logic [NUM_BANKS-1:0] wr_b, rm_b, found_b, hit_b, pend_b;
  logic [TOT_W-1:0]     total_q, total_n;
  logic                 room, rm_done;

  assign pol       = policy_e'(policy);
  assign room      = (total_q < TOT_W'(MAX_OUTSTANDING));
  assign st_accept = st_en && room && !bank_full[st_bank];
  assign st_reject = st_en && !st_accept;
  assign rm_done   = rm_en && found_b[rm_bank];
  assign rm_miss   = rm_en && !found_b[rm_bank];
  assign q_row_hit = hit_b[q_bank];
  assign q_pending = pend_b[q_bank];

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
    logic [CNT_W-1:0]       cnt;
    logic [DEPTH*ROW_W-1:0] rows;
    logic [DEPTH*TAG_W-1:0] tags;

    assign wr_b[gb] = st_accept && (st_bank == BANK_W'(gb));
    assign rm_b[gb] = rm_en && (rm_bank == BANK_W'(gb));

    frfcfs_bank_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) queue_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol       (pol),
      .wr_en     (wr_b[gb]),
      .wr_row    (st_row),
      .wr_tag    (st_tag),
      .rm_en     (rm_b[gb]),
      .rm_tag    (rm_tag),
      .rm_found  (found_b[gb]),
      .full      (bank_full[gb]),
      .count     (cnt),
      .rows_flat (rows),
      .tags_flat (tags)
    );

    frfcfs_bank_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W), .TAG_W(TAG_W)) pick_i (
      .pol       (pol),
      .active    (bank_active[gb]),
      .open_row  (open_row[gb*ROW_W +: ROW_W]),
      .count     (cnt),
      .rows_flat (rows),
      .tags_flat (tags),
      .q_row     (q_row),
      .sel_valid (sel_valid[gb]),
      .sel_tag   (sel_tag[gb*TAG_W +: TAG_W]),
      .row_hit   (hit_b[gb]),
      .pending   (pend_b[gb])
    );
  end

  always_comb begin
    total_n = total_q;
    if (st_accept && !rm_done) total_n = total_q + TOT_W'(1);
    if (rm_done && !st_accept) total_n = total_q - TOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     total_q <= '0;
    else if (st_accept || rm_done)  total_q <= total_n;
  end

  AST_TOTAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= TOT_W'(MAX_OUTSTANDING)); // R10
  AST_MISS_KEEPS_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_miss && !st_accept) |=> (total_q == $past(total_q))); // R5
  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_b)); // R1
  AST_REJECT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_reject |-> (wr_b == '0)); // R11
endmodule

// File: tb/frfcfs_sched_tb_top.sv
`timescale 1ns/1ps
module frfcfs_sched_tb_top;
  localparam int NB = 4, DP = 4, RW = 3, TW = 4, MAXO = 10;
  localparam int BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic policy;
  logic [NB-1:0] bank_active;
  logic [NB*RW-1:0] open_row;
  logic st_en, rm_en, st_accept, st_reject, rm_miss, q_row_hit, q_pending;
  logic [BW-1:0] st_bank, rm_bank, q_bank;
  logic [RW-1:0] st_row, q_row;
  logic [TW-1:0] st_tag, rm_tag;
  logic [NB-1:0] sel_valid, bank_full;
  logic [NB*TW-1:0] sel_tag;

  int tests = 0, fails = 0;
  bit done = 0;
  int m_row [NB][DP];
  int m_tag [NB][DP];
  int m_cnt [NB];
  int m_tot;

  always #2.5 clk = ~clk;

  frfcfs_sched #(.NUM_BANKS(NB), .DEPTH(DP), .ROW_W(RW), .TAG_W(TW),
                 .MAX_OUTSTANDING(MAXO)) dut_i (
    .clk(clk), .rst_n(rst_n), .policy(policy), .bank_active(bank_active),
    .open_row(open_row), .st_en(st_en), .st_bank(st_bank), .st_row(st_row),
    .st_tag(st_tag), .st_accept(st_accept), .st_reject(st_reject),
    .rm_en(rm_en), .rm_bank(rm_bank), .rm_tag(rm_tag), .rm_miss(rm_miss),
    .sel_valid(sel_valid), .sel_tag(sel_tag), .bank_full(bank_full),
    .q_bank(q_bank), .q_row(q_row), .q_row_hit(q_row_hit), .q_pending(q_pending));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int orow(int b);
    return int'(open_row[b*RW +: RW]);
  endfunction

  function automatic int f_sel(int b);
    if (m_cnt[b] == 0) return 0;
    if (policy && bank_active[b])
      for (int i = 0; i < m_cnt[b]; i++) if (m_row[b][i] == orow(b)) return m_tag[b][i];
    return m_tag[b][0];
  endfunction

  function automatic int f_rmpos(int b, int t);
    if (!policy) return (m_cnt[b] > 0) ? 0 : -1;
    for (int i = 0; i < m_cnt[b]; i++) if (m_tag[b][i] == t) return i;
    return -1;
  endfunction

  function automatic bit f_hit(int b, int r);
    int n = 0;
    if (!policy) return (m_cnt[b] >= 2) && (m_row[b][1] == r);
    for (int i = 0; i < m_cnt[b]; i++) if (m_row[b][i] == r) n++;
    return n >= 2;
  endfunction

  function automatic bit f_acc();
    return st_en && (m_tot < MAXO) && (m_cnt[st_bank] < DP);
  endfunction

  task automatic idle();
    st_en = 0; rm_en = 0; st_bank = 0; st_row = 0; st_tag = 0;
    rm_bank = 0; rm_tag = 0;
  endtask

  task automatic eval();
    #1;
    for (int b = 0; b < NB; b++) begin
      chk((policy && bank_active[b]) ? "R3" : "R4", int'(sel_valid[b]), int'(m_cnt[b] > 0));
      chk((policy && bank_active[b]) ? "R3" : "R4", int'(sel_tag[b*TW +: TW]), f_sel(b));
      chk("R11", int'(bank_full[b]), int'(m_cnt[b] == DP));
    end
    chk((m_cnt[st_bank] == DP) ? "R11" : "R10", int'(st_accept), int'(f_acc()));
    chk((m_cnt[st_bank] == DP) ? "R11" : "R10", int'(st_reject), int'(st_en && !f_acc()));
    chk(policy ? "R5" : "R6", int'(rm_miss), int'(rm_en && f_rmpos(rm_bank, rm_tag) < 0));
    chk(policy ? "R7" : "R8", int'(q_row_hit), int'(f_hit(q_bank, q_row)));
    chk("R9", int'(q_pending), int'(m_cnt[q_bank] >= 2));
  endtask

  task automatic commit();
    bit acc = f_acc();
    int p = rm_en ? f_rmpos(rm_bank, rm_tag) : -1;
    @(posedge clk);
    if (p >= 0) begin
      for (int i = p; i < m_cnt[rm_bank] - 1; i++) begin
        m_row[rm_bank][i] = m_row[rm_bank][i+1];
        m_tag[rm_bank][i] = m_tag[rm_bank][i+1];
      end
      m_cnt[rm_bank]--; m_tot--;
    end
    if (acc) begin
      m_row[st_bank][m_cnt[st_bank]] = st_row;
      m_tag[st_bank][m_cnt[st_bank]] = st_tag;
      m_cnt[st_bank]++; m_tot++;
    end
    @(negedge clk);
  endtask

  task automatic put(int b, int r, int t);
    idle(); st_en = 1; st_bank = BW'(b); st_row = RW'(r); st_tag = TW'(t);
    eval(); commit();
  endtask

  task automatic take(int b, int t);
    idle(); rm_en = 1; rm_bank = BW'(b); rm_tag = TW'(t);
    eval(); commit();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) m_cnt[b] = 0;
    m_tot = 0;
    policy = 0; bank_active = '0; open_row = '0; q_bank = 0; q_row = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R4", int'(sel_valid), 0);
    chk("R11", int'(bank_full), 0);
    chk("R9", int'(q_pending), 0);

    // in-order arrival and selection
    put(0, 5, 1); put(0, 5, 2); put(0, 2, 3);
    idle(); eval(); chk("R1", int'(sel_tag[0 +: TW]), 1); commit();
    idle(); eval(); commit();
    idle(); eval(); chk("R2", int'(sel_tag[0 +: TW]), 1); commit();
    q_bank = 0; q_row = 5; eval(); chk("R8", int'(q_row_hit), 1); chk("R9", int'(q_pending), 1);
    q_row = 2; #1; chk("R8", int'(q_row_hit), 0);
    commit();

    // first-ready choice
    policy = 1; bank_active[0] = 1; open_row[0 +: RW] = 2;
    eval(); chk("R3", int'(sel_tag[0 +: TW]), 3);
    open_row[0 +: RW] = 7; #1; chk("R3", int'(sel_tag[0 +: TW]), 1);
    q_row = 5; #1; chk("R7", int'(q_row_hit), 1);
    q_row = 2; #1; chk("R7", int'(q_row_hit), 0);
    commit();

    // removal by tag from the middle, and a miss
    take(0, 2);
    bank_active[0] = 0; eval(); chk("R5", int'(sel_tag[0 +: TW]), 1);
    bank_active[0] = 1; open_row[0 +: RW] = 2; #1; chk("R5", int'(sel_tag[0 +: TW]), 3);
    commit();
    idle(); rm_en = 1; rm_bank = 0; rm_tag = 9; eval(); chk("R5", int'(rm_miss), 1); commit();

    // store and remove together on one bank
    idle(); st_en = 1; st_bank = 0; st_row = 6; st_tag = 4;
    rm_en = 1; rm_bank = 0; rm_tag = 1; eval(); commit();
    idle(); bank_active[0] = 0; eval(); chk("R12", int'(sel_tag[0 +: TW]), 3);
    bank_active[0] = 1; open_row[0 +: RW] = 6; #1; chk("R12", int'(sel_tag[0 +: TW]), 4);
    commit();

    // in-order pop ignores the tag
    policy = 0; bank_active = '0;
    take(0, 15);
    idle(); eval(); chk("R6", int'(sel_tag[0 +: TW]), 4); commit();
    take(0, 0);
    idle(); rm_en = 1; rm_bank = 0; eval(); chk("R6", int'(rm_miss), 1); commit();

    // full bank
    for (int i = 0; i < DP; i++) put(1, i, 5 + i);
    idle(); st_en = 1; st_bank = 1; st_tag = 12; eval();
    chk("R11", int'(bank_full[1]), 1); chk("R11", int'(st_reject), 1);
    commit();
    idle(); eval(); chk("R11", int'(sel_tag[1*TW +: TW]), 5); commit();

    // global limit
    for (int i = 0; i < DP; i++) put(2, i, i);
    put(3, 1, 1); put(3, 2, 2);
    idle(); st_en = 1; st_bank = 3; st_tag = 3; eval();
    chk("R10", int'(st_accept), 0); commit();
    take(1, 0);
    idle(); st_en = 1; st_bank = 3; st_tag = 3; eval();
    chk("R10", int'(st_accept), 1); commit();

    // random mix against the model
    void'($urandom(32'd1234));
    for (int n = 0; n < 5000; n++) begin
      idle();
      if ($urandom_range(0, 19) == 0) policy = ~policy;
      bank_active = NB'($urandom);
      open_row = (NB*RW)'($urandom);
      st_en = ($urandom_range(0, 9) < 5);
      st_bank = BW'($urandom); st_row = RW'($urandom); st_tag = TW'($urandom);
      rm_en = ($urandom_range(0, 9) < 5);
      rm_bank = BW'($urandom);
      if (m_cnt[rm_bank] > 0 && $urandom_range(0, 9) < 7)
        rm_tag = TW'(m_tag[rm_bank][$urandom_range(0, m_cnt[rm_bank] - 1)]);
      else
        rm_tag = TW'($urandom);
      q_bank = BW'($urandom); q_row = RW'($urandom);
      eval(); commit();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule